// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block gives software control of sixteen general-purpose pins through a small synchronous register bus. Each pin has its own direction bit. Its output value lives in a data register, and software can rewrite that register whole or change selected bits by writing ones to set, clear or toggle addresses. Because of these write-one addresses, no read-modify-write sequence is needed when several agents share the port. Software reads the sensed level of every pin from a status address. The pin inputs first pass through a two-stage synchroniser.

Each pin can raise an interrupt. A per-pin sense bit makes the pin level sensitive or edge sensitive. For edge-sensitive pins, a second bit chooses between rising edges only and both edges. An edge is latched as a pending event, and it stays pending until software writes a one to its bit. Mask bits are changed only through separate write-one set and clear addresses. On input pins the interrupt source is the synchronised pin level. On output pins the source is the data register, so software can raise an interrupt by writing data. All sources are masked and then combined into one interrupt line.

Top module: `gpio_port16`

## Requirements
- R1: After reset all pins are inputs (`pin_oe` = 0), the data register, masks, sense, edge-mode and pending bits are 0, and `irq` is low.
- R2: The direction register sits at address 0 and can be read and written; bit 1 makes a pin an output. `pin_oe` equals the direction register and `pin_out` equals the data register.
- R3: Addresses 8 to 15 act on the data register, and address bit 2 selects set. A write with set selected drives high every bit whose write-data bit is 1. Bits with write-data 0 keep their value. A read in this range returns the data register.
- R4: In the same window, address bit 1 selects clear and address bit 0 selects toggle. These clear or invert only the bits whose write-data bit is 1.
- R5: A write to address 8 loads the data register directly. When one write selects more than one operation, set takes priority, then clear, then toggle.
- R6: A read of address 1 returns `pin_in` after two clock edges of synchronisation. Pin changes are not visible after only one edge.
- R7: A write-one to address 2 sets mask bits and a write-one to address 3 clears them. Both addresses read back the mask.
- R8: Address 4 holds the sense bits (1 = edge) and address 5 holds the edge-mode bits (1 = both edges, 0 = rising only). On an edge-sensitive pin, a qualifying edge sets a pending bit. The bit stays set until a one is written to it at address 6, and falls on rising-only pins are ignored.
- R9: For a level-sensitive pin, the status read at address 6 follows the current source level with no latching. For an edge-sensitive pin, it shows the pending bit.
- R10: `irq` is the OR of status AND mask. An input pin's source is its synchronised level, and an output pin's source is its data bit, so data writes can trigger it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| pin_in | input | 16 | Levels sensed at the pins |
| pin_out | output | 16 | Values driven on output pins |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The bench writes to the combined set/clear/toggle addresses so that all three operations hit the same bits at once. A design with the priority order wrong would leave a different data value in place. It reads the status register one edge and two edges after a pin change, which catches a synchroniser that is too short or too long. The bench drives falls on rising-only pins and checks that they leave nothing pending. It then releases an edge-latched pin and checks that the bit stays pending until the write-one clear. It also toggles an output pin's data and expects only the rising toggle to raise the interrupt.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int unsigned GP_ADDR_W = 4;

  typedef enum logic [2:0] {
    RG_DIR   = 3'd0,
    RG_LEVEL = 3'd1,
    RG_MSET  = 3'd2,
    RG_MCLR  = 3'd3,
    RG_SENSE = 3'd4,
    RG_BOTH  = 3'd5,
    RG_PEND  = 3'd6,
    RG_RSVD  = 3'd7
  } ctl_reg_e;

  typedef struct packed {
    logic direct;
    logic set;
    logic clr;
    logic tgl;
  } data_op_t;

endpackage

// File: rtl/gpio_outreg.sv
module gpio_outreg
  import gpio_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  data_op_t     op_i,
  input  logic         dir_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] data_q
);

  // Priority: direct load, then set, then clear, then toggle.
  function automatic logic [W-1:0] f_modify(input logic [W-1:0] cur,
                                            input logic [W-1:0] wd,
                                            input data_op_t      op);
    if (op.direct)   return wd;
    else if (op.set) return cur | wd;
    else if (op.clr) return cur & ~wd;
    else if (op.tgl) return cur ^ wd;
    else             return cur;
  endfunction

  logic         any_op;
  logic [W-1:0] data_next;

  assign any_op    = op_i.direct | op_i.set | op_i.clr | op_i.tgl;
  assign data_next = f_modify(data_q, wdata_i, op_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      if (dir_we_i) dir_q <= wdata_i;
      if (any_op)   data_q <= data_next;
    end
  end

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i.set && !op_i.direct) |=> ((data_q & $past(wdata_i)) == $past(wdata_i))); // R3

  AST_CLR_BEATS_TGL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i.clr && !op_i.set && !op_i.direct) |=> ((data_q & $past(wdata_i)) == '0)); // R5

  AST_ZERO_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (any_op && !op_i.direct) |=> (((data_q ^ $past(data_q)) & ~$past(wdata_i)) == '0)); // R4

endmodule

// File: rtl/gpio_insync.sv
module gpio_insync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= pin_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl_o = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_irqctl.sv
module gpio_irqctl #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] wdata_i,
  input  logic         mset_we_i,
  input  logic         mclr_we_i,
  input  logic         sense_we_i,
  input  logic         both_we_i,
  input  logic         pclr_we_i,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] sense_q,
  output logic [W-1:0] both_q,
  output logic [W-1:0] stat_o,
  output logic         irq_o
);

  function automatic logic [W-1:0] f_edge_events(input logic [W-1:0] cur,
                                                 input logic [W-1:0] prev,
                                                 input logic [W-1:0] edge_sel,
                                                 input logic [W-1:0] both_sel);
    logic [W-1:0] rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return edge_sel & (rise | (both_sel & fall));
  endfunction

  logic [W-1:0] prev_q;
  logic [W-1:0] pend_q;
  logic [W-1:0] edge_evt;   // named event vector for the checks
  logic [W-1:0] pend_wipe;

  assign edge_evt  = f_edge_events(src_i, prev_q, sense_q, both_q);
  assign pend_wipe = pclr_we_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      pend_q  <= '0;
      mask_q  <= '0;
      sense_q <= '0;
      both_q  <= '0;
    end else begin
      prev_q <= src_i;
      pend_q <= (pend_q & ~pend_wipe) | edge_evt;
      if (mset_we_i)       mask_q <= mask_q | wdata_i;
      else if (mclr_we_i)  mask_q <= mask_q & ~wdata_i;
      if (sense_we_i) sense_q <= wdata_i;
      if (both_we_i)  both_q  <= wdata_i;
    end
  end

  assign stat_o = (sense_q & pend_q) | (~sense_q & src_i);
  assign irq_o  = |(stat_o & mask_q);

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !pclr_we_i |=> (($past(pend_q) & ~pend_q) == '0)); // R8

  AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(src_i ^ prev_q)) == '0); // R8

  AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o); // R10

endmodule

// File: rtl/gpio_port16.sv
module gpio_port16
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS     = 16,
  parameter int unsigned SYNC_FLOPS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [GP_ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]     bus_wdata,
  output logic [NPINS-1:0]     bus_rdata,
  input  logic [NPINS-1:0]     pin_in,
  output logic [NPINS-1:0]     pin_out,
  output logic [NPINS-1:0]     pin_oe,
  output logic                 irq
);

  localparam int unsigned CTL_BITS = GP_ADDR_W - 1;

  logic                data_win;
  ctl_reg_e            ctl_sel;
  data_op_t            data_op;
  logic [NPINS-1:0]    dir_q, data_q, lvl_s, src_v;
  logic [NPINS-1:0]    mask_q, sense_q, both_q, stat_v;

  assign data_win = bus_addr[GP_ADDR_W-1];
  assign ctl_sel  = ctl_reg_e'(bus_addr[CTL_BITS-1:0]);

  always_comb begin
    data_op        = '0;
    if (bus_wr && data_win) begin
      data_op.direct = (bus_addr[2:0] == 3'b000);
      data_op.set    = bus_addr[2];
      data_op.clr    = bus_addr[1];
      data_op.tgl    = bus_addr[0];
    end
  end

  gpio_outreg #(.W(NPINS)) u_outreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (data_op),
    .dir_we_i (bus_wr && !data_win && ctl_sel == RG_DIR),
    .wdata_i  (bus_wdata),
    .dir_q    (dir_q),
    .data_q   (data_q)
  );

  gpio_insync #(.W(NPINS), .STAGES(SYNC_FLOPS)) u_insync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_in),
    .lvl_o (lvl_s)
  );

  // Output pins take their interrupt source from the data register.
  assign src_v = (dir_q & data_q) | (~dir_q & lvl_s);

  gpio_irqctl #(.W(NPINS)) u_irqctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_v),
    .wdata_i    (bus_wdata),
    .mset_we_i  (bus_wr && !data_win && ctl_sel == RG_MSET),
    .mclr_we_i  (bus_wr && !data_win && ctl_sel == RG_MCLR),
    .sense_we_i (bus_wr && !data_win && ctl_sel == RG_SENSE),
    .both_we_i  (bus_wr && !data_win && ctl_sel == RG_BOTH),
    .pclr_we_i  (bus_wr && !data_win && ctl_sel == RG_PEND),
    .mask_q     (mask_q),
    .sense_q    (sense_q),
    .both_q     (both_q),
    .stat_o     (stat_v),
    .irq_o      (irq)
  );

  always_comb begin
    if (data_win) bus_rdata = data_q;
    else begin
      case (ctl_sel)
        RG_DIR:            bus_rdata = dir_q;
        RG_LEVEL:          bus_rdata = lvl_s;
        RG_MSET, RG_MCLR:  bus_rdata = mask_q;
        RG_SENSE:          bus_rdata = sense_q;
        RG_BOTH:           bus_rdata = both_q;
        RG_PEND:           bus_rdata = stat_v;
        default:           bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;

  AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == '0) |=> (pin_oe == $past(bus_wdata))); // R2

endmodule

// File: tb/gpio_port16_tb_top.sv
`timescale 1ns/100ps
module gpio_port16_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata, pin_out, pin_oe, pin_in;
  logic [15:0] ext_in = '0;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  // Pads loop driven values back; inputs come from the outside world.
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_in);

  gpio_port16 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 pin_oe, 3 pin_out
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb_q[$];
  event     mon_ev;

  // Monitor: pops the next expected item and compares against the ports.
  initial begin
    forever begin
      @(mon_ev);
      #0.2;
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0:       act = bus_rdata;
          1:       act = {15'd0, irq};
          2:       act = pin_oe;
          default: act = pin_out;
        endcase
        n_vec++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [3:0] a,
                             input logic [15:0] e, input string tag);
    sb_item_t it;
    bus_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    -> mon_ev;
    #0.4;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Restatement of the data-register rule: set over clear over toggle.
  function automatic logic [15:0] model_mod(input logic [15:0] cur,
                                            input logic [15:0] wd,
                                            input logic [2:0] sct);
    if (sct == 3'b000) return wd;
    if (sct[2]) return cur | wd;
    if (sct[1]) return cur & ~wd;
    return cur ^ wd;
  endfunction

  logic [15:0] m_data;

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    expect_item(0, 4'd0, 16'h0000, "R1 dir");
    expect_item(0, 4'd8, 16'h0000, "R1 data");
    expect_item(0, 4'd2, 16'h0000, "R1 mask");
    expect_item(1, 4'd6, 16'h0000, "R1 irq");

    // R2 direction
    bus_write(4'd0, 16'h00FF);
    expect_item(2, 4'd0, 16'h00FF, "R2 oe");
    expect_item(0, 4'd0, 16'h00FF, "R2 dir read");

    // R5 direct, R3 set, R4 clear/toggle
    m_data = model_mod(16'h0000, 16'h0F0F, 3'b000);
    bus_write(4'd8, 16'h0F0F);
    expect_item(0, 4'd8, m_data, "R5 direct load");
    expect_item(3, 4'd8, m_data, "R2 pin_out");
    m_data = model_mod(m_data, 16'h00F0, 3'b100);
    bus_write(4'd12, 16'h00F0);
    expect_item(0, 4'd8, m_data, "R3 set");
    m_data = model_mod(m_data, 16'h0F00, 3'b010);
    bus_write(4'd10, 16'h0F00);
    expect_item(0, 4'd8, m_data, "R4 clear");
    m_data = model_mod(m_data, 16'h0101, 3'b001);
    bus_write(4'd9, 16'h0101);
    expect_item(0, 4'd8, m_data, "R4 toggle");
    m_data = model_mod(m_data, 16'h0003, 3'b110);
    bus_write(4'd14, 16'h0003);
    expect_item(0, 4'd8, m_data, "R5 set over clear");
    m_data = model_mod(m_data, 16'h0010, 3'b011);
    bus_write(4'd11, 16'h0010);
    expect_item(0, 4'd8, m_data, "R5 clear over toggle");
    m_data = model_mod(m_data, 16'h1000, 3'b111);
    bus_write(4'd15, 16'h1000);
    expect_item(0, 4'd8, m_data, "R5 set over all");
    expect_item(0, 4'd8, 16'h11EF, "R5 literal");

    // R6 two-edge synchroniser
    idle(3);
    expect_item(0, 4'd1, 16'h00EF, "R6 before");
    ext_in = 16'hA500;
    idle(1);
    expect_item(0, 4'd1, 16'h00EF, "R6 one edge");
    idle(1);
    expect_item(0, 4'd1, 16'hA5EF, "R6 two edges");

    // R7 masks
    bus_write(4'd2, 16'h8001);
    expect_item(0, 4'd3, 16'h8001, "R7 mask set");
    bus_write(4'd3, 16'h0001);
    expect_item(0, 4'd2, 16'h8000, "R7 mask clear");
    expect_item(1, 4'd2, 16'h0001, "R10 level irq");
    expect_item(0, 4'd6, 16'hA5EF, "R9 level status");
    bus_write(4'd3, 16'h8000);
    expect_item(1, 4'd2, 16'h0000, "R10 masked off");
    ext_in = 16'h2500;
    idle(2);
    expect_item(0, 4'd6, 16'h25EF, "R9 follows level");

    // R8 edges
    bus_write(4'd4, 16'hFF00);
    bus_write(4'd5, 16'hF000);
    expect_item(0, 4'd4, 16'hFF00, "R8 sense read");
    expect_item(0, 4'd6, 16'h00EF, "R8 no pending");
    ext_in = 16'h0300;
    idle(3);
    expect_item(0, 4'd6, 16'h22EF, "R8 rise and both-edge fall");
    ext_in = 16'h2500;
    idle(3);
    expect_item(0, 4'd6, 16'h26EF, "R8 sticky pending");
    bus_write(4'd2, 16'h0200);
    expect_item(1, 4'd6, 16'h0001, "R10 pending irq");
    bus_write(4'd6, 16'h0200);
    expect_item(0, 4'd6, 16'h24EF, "R8 w1 clear");
    expect_item(1, 4'd6, 16'h0000, "R10 irq after clear");

    // R10 software trigger on an output pin
    bus_write(4'd4, 16'hFF01);
    bus_write(4'd2, 16'h0001);
    expect_item(1, 4'd6, 16'h0000, "R10 armed quiet");
    bus_write(4'd9, 16'h0001);
    idle(1);
    expect_item(1, 4'd6, 16'h0000, "R10 fall ignored");
    bus_write(4'd9, 16'h0001);
    idle(1);
    expect_item(1, 4'd6, 16'h0001, "R10 software rise");
    expect_item(0, 4'd6, 16'h24EF, "R8 output pin pending");

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule